// File: doc/BRIEF.md
# Byte/Halfword Swap and Rotate Unit

This unit takes a 64-bit operand and rearranges it in one of four ways. It can exchange the two bytes of every halfword, either in the low 32-bit word only or across the whole doubleword. It can reverse the order of the four halfwords. It can also rotate the operand right by 32 plus a 5-bit amount. In the word-only byte swap, the 32-bit result is sign-extended to 64 bits.

A request is accepted in a cycle where `valid_i` is high. The unit then presents the registered result, with `valid_o`, one clock later. When no request is issued, the result register keeps its last value. The unit is meant to sit as a small leaf in an integer execute stage, and instruction decode stays with the caller.

Top module: `byte_rot_unit`

## Requirements
- R1: After reset is asserted (`rst_ni` low), `valid_o` is 0 and `result_o` is 0.
- R2: `valid_o` is 1 in the cycle after a cycle in which `valid_i` was 1, and 0 after a cycle in which `valid_i` was 0.
- R3: With `op_i` = 0, result bits 31:0 are operand bits 31:0 with the two bytes of each halfword exchanged (byte 0 with byte 1, byte 2 with byte 3).
- R4: With `op_i` = 0, result bits 63:32 are all copies of result bit 31. Operand bits 63:32 have no effect.
- R5: With `op_i` = 1, the two bytes of each of the four halfwords of the operand are exchanged.
- R6: With `op_i` = 2, the order of the four halfwords is reversed: result halfword k equals operand halfword 3-k.
- R7: With `op_i` = 3, the result is the operand rotated right by 32 + `amt_i`. When `amt_i` = 0 the rotate is by 32, not a pass-through. When `amt_i` = 31 the rotate is by 63.
- R8: While `valid_i` is 0, `result_o` holds its value, whatever `data_i`, `op_i` and `amt_i` do.
- R9: For `op_i` values 0, 1 and 2, `amt_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue a request this cycle |
| op_i | input | 2 | 0 word byte swap, 1 doubleword byte swap, 2 halfword reverse, 3 rotate |
| amt_i | input | 5 | Extra rotate amount added to 32 |
| data_i | input | 64 | Operand |
| valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Registered result |

## Verification
Every operation has exactly one register between the operand and `result_o`. Each result is therefore due in the cycle that follows the rising edge on which `valid_i` was sampled high. The bench applies inputs on the falling edge and lets one rising edge pass. It then drops `valid_i` and reads `result_o` and `valid_o` on the next falling edge, before any second edge can change them. For the hold checks, the bench changes the operand with `valid_i` low. It then reads the outputs again after another full cycle, to confirm that nothing moved.

// File: rtl/byte_rot_pkg.sv
package byte_rot_pkg;
  typedef enum logic [1:0] {
    OP_WSWAP = 2'd0,
    OP_DSWAP = 2'd1,
    OP_HREV  = 2'd2,
    OP_ROT   = 2'd3
  } op_e;
endpackage

// File: rtl/byte_lane_swap.sv
module byte_lane_swap #(
  parameter int W = 64
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int NH = W / 16;
  for (genvar g = 0; g < NH; g++) begin : g_hw
    assign q_o[16*g +: 16] = {d_i[16*g +: 8], d_i[16*g+8 +: 8]};
  end
endmodule

// File: rtl/halfword_reverse.sv
module halfword_reverse #(
  parameter int W = 64
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int NH = W / 16;
  for (genvar g = 0; g < NH; g++) begin : g_hw
    assign q_o[16*g +: 16] = d_i[16*(NH-1-g) +: 16];
  end
endmodule

// File: rtl/offset_rotator.sv
module offset_rotator #(
  parameter int W     = 64,
  parameter int AMT_W = 5
) (
  input  logic [W-1:0]     d_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     q_o
);
  localparam int HALF = W / 2;
  logic [W-1:0] stg [AMT_W+1];

  // fixed half-width offset is pure wiring
  assign stg[0] = {d_i[HALF-1:0], d_i[W-1:HALF]};

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt_i[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
  end

  assign q_o = stg[AMT_W];
endmodule

// File: rtl/byte_rot_unit.sv
module byte_rot_unit
  import byte_rot_pkg::*;
#(
  parameter int W     = 64,
  parameter int AMT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [W-1:0]     data_i,
  output logic             valid_o,
  output logic [W-1:0]     result_o
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] wswap;
  logic [W-1:0]    dswap, hrev, rot, nxt;

  byte_lane_swap #(.W(HALF)) u_wswap (.d_i(data_i[HALF-1:0]), .q_o(wswap));
  byte_lane_swap #(.W(W))    u_dswap (.d_i(data_i), .q_o(dswap));
  halfword_reverse #(.W(W))  u_hrev  (.d_i(data_i), .q_o(hrev));
  offset_rotator #(.W(W), .AMT_W(AMT_W)) u_rot (.d_i(data_i), .amt_i(amt_i), .q_o(rot));

  always_comb begin
    unique case (op_e'(op_i))
      OP_WSWAP: nxt = {{HALF{wswap[HALF-1]}}, wswap};
      OP_DSWAP: nxt = dswap;
      OP_HREV:  nxt = hrev;
      default:  nxt = rot;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end
endmodule

// File: rtl/byte_rot_chk.sv
module byte_rot_chk
  import byte_rot_pkg::*;
#(
  parameter int W     = 64,
  parameter int AMT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [W-1:0]     data_i,
  input logic             valid_o,
  input logic [W-1:0]     result_o
);
  localparam int HALF = W / 2;

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  // R4
  wswap_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_WSWAP) |=> (result_o[W-1:HALF] == {HALF{result_o[HALF-1]}}));

  // R7
  rot_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ROT) |=> ($countones(result_o) == $countones($past(data_i))));

  // R6
  hrev_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_HREV) |=> (result_o[15:0] == $past(data_i[W-1:W-16])));

  // R5
  dswap_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_DSWAP) |=> ($countones(result_o) == $countones($past(data_i))));
endmodule

bind byte_rot_unit byte_rot_chk #(.W(W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/sim_byte_rot_unit.sv
`timescale 1ns/1ps
module sim_byte_rot_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [4:0]  amt_i = '0;
  logic [63:0] data_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  byte_rot_unit u0 (.*);

  always #2 clk_i = ~clk_i;

  localparam int NV = 12;
  localparam logic [63:0] TV_D [NV] = '{
    64'h0123456789ABCDEF, 64'hFFFF0000_80017F02, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF,
    64'h0123456789ABCDEF, 64'h8000000000000001, 64'hDEADBEEFCAFEF00D, 64'h00000000_00FF0000,
    64'hA5A5_5A5A_0F0F_F0F0, 64'h1122334455667788, 64'hFEDCBA9876543210, 64'h0000000100000000};
  localparam logic [1:0] TV_OP [NV] = '{0, 0, 1, 2, 3, 3, 3, 0, 1, 2, 3, 3};
  localparam logic [4:0] TV_AMT [NV] = '{0, 7, 3, 9, 0, 31, 13, 0, 0, 31, 1, 16};

  function automatic logic [63:0] model(logic [63:0] d, logic [1:0] op, logic [4:0] amt);
    logic [63:0]  r;
    logic [31:0]  lo;
    logic [127:0] t;
    r = '0;
    case (op)
      2'd0: begin
        for (int b = 0; b < 4; b++) lo[8*b +: 8] = d[8*(b^1) +: 8];
        r = {{32{lo[31]}}, lo};
      end
      2'd1: for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(b^1) +: 8];
      2'd2: for (int h = 0; h < 4; h++) r[16*h +: 16] = d[16*(3-h) +: 16];
      default: begin
        t = {d, d} >> (32 + amt);
        r = t[63:0];
      end
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [63:0] d, logic [1:0] op, logic [4:0] amt);
    data_i = d; op_i = op; amt_i = amt; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 valid", {63'd0, valid_o}, 64'd0);
    check("R1 result", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      issue(TV_D[i], TV_OP[i], TV_AMT[i]);
      check("R2 valid", {63'd0, valid_o}, 64'd1);
      check($sformatf("R3/R4/R5/R6/R7 vec %0d", i), result_o,
            model(TV_D[i], TV_OP[i], TV_AMT[i]));
    end

    // directed corner values
    issue(64'h0123456789ABCDEF, 2'd3, 5'd0);
    check("R7 amt0 rotates by 32", result_o, 64'h89ABCDEF01234567);
    issue(64'h8000000000000001, 2'd3, 5'd31);
    check("R7 amt31 rotates by 63", result_o, 64'h0000000000000003);
    issue(64'h0123456789ABCDEF, 2'd2, 5'd0);
    check("R6 reverse", result_o, 64'hCDEF89AB45670123);
    issue(64'h0123456789ABCDEF, 2'd1, 5'd0);
    check("R5 dword swap", result_o, 64'h23016745AB89EFCD);
    issue(64'h00000000_12348001, 2'd0, 5'd0);
    check("R3 word swap", result_o, 64'h0000000034120180);
    issue(64'h12345678_00FF0000, 2'd0, 5'd0);
    check("R4 sign extend", result_o, 64'hFFFFFFFFFF000000);

    // R9: amt ignored for non-rotate ops
    issue(64'h0123456789ABCDEF, 2'd1, 5'd31);
    check("R9 dswap amt", result_o, 64'h23016745AB89EFCD);
    issue(64'h0123456789ABCDEF, 2'd2, 5'd17);
    check("R9 hrev amt", result_o, 64'hCDEF89AB45670123);
    issue(64'h00000000_12348001, 2'd0, 5'd5);
    check("R9 wswap amt", result_o, 64'h0000000034120180);

    // R8: hold while idle
    data_i = 64'hFFFFFFFFFFFFFFFF; op_i = 2'd3; amt_i = 5'd4;
    @(negedge clk_i);
    check("R2 idle valid", {63'd0, valid_o}, 64'd0);
    data_i = 64'h5555555555555555; op_i = 2'd1;
    @(negedge clk_i);
    check("R8 hold", result_o, 64'h0000000034120180);

    // R1: asynchronous reset mid-run
    issue(64'h0123456789ABCDEF, 2'd3, 5'd0);
    rst_ni = 1'b0;
    #1;
    check("R1 async valid", {63'd0, valid_o}, 64'd0);
    check("R1 async result", result_o, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule